// File: doc/BRIEF.md
# Sleep Wake-up Clock Restart Controller

This block manages the low-power states of a processor subsystem. A power-save command moves it from normal running into one of two states. In idle, only the CPU clock is gated and the peripheral clocks keep running. In sleep, both the CPU and the peripheral clocks are gated and the main oscillator is stopped. The one exception is a low-power crystal that has been configured to keep running through sleep. The block runs on an always-on clock, so it keeps working while the gated clocks are off.

When a qualifying event arrives during sleep, the controller restarts the clock source that was active at sleep entry. It holds the system clock off until the start-up condition for that source has been met:

- Every source waits out a short fixed delay.
- A crystal also waits for its start-up timer.
- A PLL source also waits for lock.
- A low-power crystal that kept running in sleep needs only the fixed delay.

The release signal then goes high and the gated clocks are enabled again. Leaving idle needs no hold-off.

Top module: `pwr_sleep_ctl`

## Requirements
- R1: After reset the block is running: cpu_clk_en, per_clk_en, osc_run and clk_release are all 1.
- R2: In the running state, a command with cmd_valid=1 and cmd_sleep=0 enters idle from the next cycle. In idle, cpu_clk_en=0, per_clk_en=1, osc_run=1 and clk_release=1.
- R3: In the running state, a command with cmd_valid=1 and cmd_sleep=1 enters sleep. In sleep, cpu_clk_en, per_clk_en and clk_release are 0. osc_run is 0 unless the captured source is code 5 (low-power crystal) and lp_keep was 1 at entry; in that case osc_run is 1.
- R4: lprc_run is 1 whenever wdt_en is 1. In sleep with wdt_en=0, lprc_run is 0.
- R5: Sleep ends on any of three events: a request line that is enabled and whose 3-bit priority is strictly greater than cpu_level, any bit of rst_src, or wdt_timeout while wdt_en=1. A request that is disabled or not above cpu_level does not end sleep. Neither does wdt_timeout while wdt_en=0.
- R6: Idle ends on any enabled request regardless of priority, on any rst_src bit, or on a watchdog timeout. cpu_clk_en is 1 again from the next cycle.
- R7: The restart source is captured at sleep entry. It is osc_sel when clk_switch_en=1, and the parameter DEF_SRC otherwise. Changes to osc_sel during sleep have no effect.
- R8: For source codes 0, 1, 2, 3 and 7, and for code 5 kept running in sleep, clk_release rises exactly POR_CYCLES+1 cycles after the cycle in which the wake event was sampled.
- R9: For code 4 (crystal), and for code 5 not kept running, clk_release stays 0 until ost_done=1 after the fixed delay. pll_lock has no effect for these sources.
- R10: For code 6 (PLL), clk_release stays 0 until pll_lock=1 after the fixed delay. ost_done has no effect for this source.
- R11: While clk_release is 0, cpu_clk_en and per_clk_en are 0. During the wake-up hold-off, osc_run is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Power-save command strobe |
| cmd_sleep | input | 1 | Command parameter: 1 selects sleep, 0 selects idle |
| irq_req | input | N_IRQ | Interrupt request lines |
| irq_en | input | N_IRQ | Per-line interrupt enables |
| irq_prio | input | N_IRQ*3 | 3-bit priority per line; line i uses bits [3i+2:3i] |
| cpu_level | input | 3 | Current CPU priority level |
| rst_src | input | 3 | Reset sources: power-on, brown-out, external |
| wdt_en | input | 1 | Watchdog enabled |
| wdt_timeout | input | 1 | Watchdog timeout pulse |
| clk_switch_en | input | 1 | Clock switching enabled; osc_sel is used as the source |
| osc_sel | input | 3 | Current oscillator source code |
| lp_keep | input | 1 | Keep the low-power crystal running during sleep |
| ost_done | input | 1 | Oscillator start-up timer expired |
| pll_lock | input | 1 | PLL lock indication |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| osc_run | output | 1 | Main oscillator run enable |
| lprc_run | output | 1 | Low-power RC oscillator run enable |
| clk_release | output | 1 | System clock released |

## Verification
The bench sleeps and wakes once for every source code. For crystal-type sources it raises the wrong readiness signal (lock instead of start-up done, and the reverse); a design that mixes up the two conditions would release early. It counts the exact number of hold-off cycles for fixed-delay sources, which exposes any off-by-one error in the start-up counter. It sends requests that are disabled or not above the CPU level, and watchdog timeouts while the watchdog is off; a design with a loose wake qualifier would leave sleep on these. It also changes osc_sel during sleep and clears clock switching; a design that failed to capture the source at entry, or ignored the default source, would wait for the wrong condition.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;

  typedef enum logic [1:0] {PS_RUN, PS_IDLE, PS_SLEEP, PS_WAKE} pstate_t;
  typedef enum logic [1:0] {HOLD_FIXED, HOLD_OST, HOLD_LOCK} hold_t;

  localparam int PRIO_W = 3;
  localparam int SRC_W  = 3;

  localparam logic [SRC_W-1:0] SRC_FRC  = 3'd0;
  localparam logic [SRC_W-1:0] SRC_LPRC = 3'd1;
  localparam logic [SRC_W-1:0] SRC_EXT  = 3'd2;
  localparam logic [SRC_W-1:0] SRC_ERC  = 3'd3;
  localparam logic [SRC_W-1:0] SRC_XTAL = 3'd4;
  localparam logic [SRC_W-1:0] SRC_LPXT = 3'd5;
  localparam logic [SRC_W-1:0] SRC_PLL  = 3'd6;

  // low-power crystal left running through sleep
  function automatic logic osc_kept(logic [SRC_W-1:0] src, logic keep);
    return (src == SRC_LPXT) && keep;
  endfunction

  // which extra readiness condition a source needs after the fixed delay
  function automatic hold_t hold_kind(logic [SRC_W-1:0] src, logic keep);
    hold_t k;
    case (src)
      SRC_XTAL: k = HOLD_OST;
      SRC_LPXT: k = keep ? HOLD_FIXED : HOLD_OST;
      SRC_PLL:  k = HOLD_LOCK;
      default:  k = HOLD_FIXED;
    endcase
    return k;
  endfunction

  function automatic logic prio_ok(logic [PRIO_W-1:0] p, logic [PRIO_W-1:0] lvl);
    return p > lvl;
  endfunction

endpackage

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect
  import pwr_sleep_pkg::*;
#(
  parameter int N_IRQ = 4
) (
  input  logic [N_IRQ-1:0]        irq_req,
  input  logic [N_IRQ-1:0]        irq_en,
  input  logic [N_IRQ*PRIO_W-1:0] irq_prio,
  input  logic [PRIO_W-1:0]       cpu_level,
  input  logic [2:0]              rst_src,
  input  logic                    wdt_en,
  input  logic                    wdt_timeout,
  output logic                    sleep_wake,
  output logic                    idle_wake
);

  logic [N_IRQ-1:0] qual_line;
  logic [N_IRQ-1:0] live_line;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_line
    assign live_line[i] = irq_req[i] & irq_en[i];
    assign qual_line[i] = live_line[i] & prio_ok(irq_prio[i*PRIO_W +: PRIO_W], cpu_level);
  end

  logic common_evt;
  assign common_evt = (|rst_src) | (wdt_en & wdt_timeout);
  assign sleep_wake = (|qual_line) | common_evt;
  assign idle_wake  = (|live_line) | common_evt;

endmodule

// File: rtl/pwr_startup_timer.sv
module pwr_startup_timer #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic zero
);

  localparam int W = (CYCLES < 1) ? 1 : $clog2(CYCLES + 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= W'(CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/pwr_gate_decode.sv
module pwr_gate_decode
  import pwr_sleep_pkg::*;
(
  input  pstate_t state,
  input  logic    kept,
  output logic    cpu_en,
  output logic    per_en,
  output logic    osc_en,
  output logic    release_o
);

  always_comb begin
    cpu_en = 1'b0; per_en = 1'b0; osc_en = 1'b1; release_o = 1'b0;
    case (state)
      PS_RUN:   begin cpu_en = 1'b1; per_en = 1'b1; release_o = 1'b1; end
      PS_IDLE:  begin per_en = 1'b1; release_o = 1'b1; end
      PS_SLEEP: osc_en = kept;
      default:  ;
    endcase
  end

endmodule

// File: rtl/pwr_sleep_ctl.sv
module pwr_sleep_ctl
  import pwr_sleep_pkg::*;
#(
  parameter int          N_IRQ      = 4,
  parameter int          POR_CYCLES = 4,
  parameter logic [2:0]  DEF_SRC    = 3'd0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  input  logic                    cmd_sleep,
  input  logic [N_IRQ-1:0]        irq_req,
  input  logic [N_IRQ-1:0]        irq_en,
  input  logic [N_IRQ*3-1:0]      irq_prio,
  input  logic [2:0]              cpu_level,
  input  logic [2:0]              rst_src,
  input  logic                    wdt_en,
  input  logic                    wdt_timeout,
  input  logic                    clk_switch_en,
  input  logic [2:0]              osc_sel,
  input  logic                    lp_keep,
  input  logic                    ost_done,
  input  logic                    pll_lock,
  output logic                    cpu_clk_en,
  output logic                    per_clk_en,
  output logic                    osc_run,
  output logic                    lprc_run,
  output logic                    clk_release
);

  pstate_t    state_q;
  logic [2:0] src_q;
  logic       keep_q;

  logic sleep_wake, idle_wake;
  logic timer_load, timer_zero;
  logic hold_met;
  hold_t hold_sel;
  logic kept_now;
  logic [2:0] act_src, cur_src;
  logic in_sleep, in_idle, in_wake;

  pwr_wake_detect #(.N_IRQ(N_IRQ)) u_wake (
    .irq_req(irq_req), .irq_en(irq_en), .irq_prio(irq_prio),
    .cpu_level(cpu_level), .rst_src(rst_src), .wdt_en(wdt_en),
    .wdt_timeout(wdt_timeout), .sleep_wake(sleep_wake), .idle_wake(idle_wake)
  );

  assign in_sleep   = (state_q == PS_SLEEP);
  assign in_idle    = (state_q == PS_IDLE);
  assign in_wake    = (state_q == PS_WAKE);
  assign timer_load = in_sleep & sleep_wake;

  pwr_startup_timer #(.CYCLES(POR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(timer_load), .zero(timer_zero)
  );

  assign act_src  = clk_switch_en ? osc_sel : DEF_SRC;
  assign cur_src  = (state_q == PS_RUN) ? act_src : src_q;
  assign hold_sel = hold_kind(src_q, keep_q);
  assign kept_now = osc_kept(src_q, keep_q);

  always_comb begin
    case (hold_sel)
      HOLD_OST:  hold_met = timer_zero & ost_done;
      HOLD_LOCK: hold_met = timer_zero & pll_lock;
      default:   hold_met = timer_zero;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_RUN;
      src_q   <= DEF_SRC;
      keep_q  <= 1'b0;
    end else begin
      case (state_q)
        PS_RUN: if (cmd_valid) begin
          if (cmd_sleep) begin
            state_q <= PS_SLEEP;
            src_q   <= act_src;
            keep_q  <= lp_keep;
          end else begin
            state_q <= PS_IDLE;
          end
        end
        PS_IDLE:  if (idle_wake)  state_q <= PS_RUN;
        PS_SLEEP: if (sleep_wake) state_q <= PS_WAKE;
        PS_WAKE:  if (hold_met)   state_q <= PS_RUN;
        default:  state_q <= PS_RUN;
      endcase
    end
  end

  pwr_gate_decode u_gate (
    .state(state_q), .kept(kept_now), .cpu_en(cpu_clk_en),
    .per_en(per_clk_en), .osc_en(osc_run), .release_o(clk_release)
  );

  assign lprc_run = wdt_en | (osc_run & (cur_src == SRC_LPRC));

endmodule

// File: rtl/pwr_sleep_chk.sv
module pwr_sleep_chk
  import pwr_sleep_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  in_sleep,
  input logic  in_idle,
  input logic  in_wake,
  input logic  timer_zero,
  input hold_t hold_sel,
  input logic  kept_now,
  input logic  wdt_en,
  input logic  ost_done,
  input logic  pll_lock,
  input logic  cpu_clk_en,
  input logic  per_clk_en,
  input logic  osc_run,
  input logic  lprc_run,
  input logic  clk_release
);

  // R11
  rel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_release |-> (!cpu_clk_en && !per_clk_en));

  // R11
  wake_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_wake |-> osc_run);

  // R4
  lprc_wdt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_en |-> lprc_run);

  // R3
  sleep_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sleep && !kept_now) |-> !osc_run);

  // R2
  idle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> (per_clk_en && !cpu_clk_en && clk_release));

  // R8
  timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wake && !timer_zero) |=> !clk_release);

  // R9
  ost_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wake && hold_sel == HOLD_OST && !ost_done) |=> !clk_release);

  // R10
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wake && hold_sel == HOLD_LOCK && !pll_lock) |=> !clk_release);

endmodule

bind pwr_sleep_ctl pwr_sleep_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_sleep(in_sleep), .in_idle(in_idle),
  .in_wake(in_wake), .timer_zero(timer_zero), .hold_sel(hold_sel),
  .kept_now(kept_now), .wdt_en(wdt_en), .ost_done(ost_done),
  .pll_lock(pll_lock), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
  .osc_run(osc_run), .lprc_run(lprc_run), .clk_release(clk_release)
);

// File: tb/pwr_sleep_ctl_tb_top.sv
module pwr_sleep_ctl_tb_top;

  localparam int N_IRQ = 4;
  localparam int POR   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 0, cmd_sleep = 0;
  logic [N_IRQ-1:0] irq_req = '0, irq_en = '0;
  logic [N_IRQ*3-1:0] irq_prio = '0;
  logic [2:0] cpu_level = 3'd2, rst_src = '0, osc_sel = '0;
  logic wdt_en = 0, wdt_timeout = 0, clk_switch_en = 1, lp_keep = 0;
  logic ost_done = 0, pll_lock = 0;
  logic cpu_clk_en, per_clk_en, osc_run, lprc_run, clk_release;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwr_sleep_ctl #(.N_IRQ(N_IRQ), .POR_CYCLES(POR), .DEF_SRC(3'd6)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_sleep(cmd_sleep),
    .irq_req(irq_req), .irq_en(irq_en), .irq_prio(irq_prio),
    .cpu_level(cpu_level), .rst_src(rst_src), .wdt_en(wdt_en),
    .wdt_timeout(wdt_timeout), .clk_switch_en(clk_switch_en),
    .osc_sel(osc_sel), .lp_keep(lp_keep), .ost_done(ost_done),
    .pll_lock(pll_lock), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .osc_run(osc_run), .lprc_run(lprc_run), .clk_release(clk_release)
  );

  // vector: {src[2:0], keep, kind[1:0]}; kind 0 fixed, 1 start-up timer, 2 lock
  localparam logic [5:0] VEC [9] = '{
    {3'd0, 1'b0, 2'd0}, {3'd1, 1'b0, 2'd0}, {3'd2, 1'b0, 2'd0},
    {3'd3, 1'b0, 2'd0}, {3'd4, 1'b0, 2'd1}, {3'd5, 1'b1, 2'd0},
    {3'd5, 1'b0, 2'd1}, {3'd6, 1'b0, 2'd2}, {3'd7, 1'b0, 2'd0}
  };

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic go_sleep();
    @(negedge clk); cmd_valid = 1; cmd_sleep = 1;
    @(negedge clk); cmd_valid = 0;
  endtask

  task automatic wake_irq();
    irq_en[0] = 1; irq_prio[2:0] = 3'd5; irq_req[0] = 1;
    @(negedge clk); irq_req[0] = 0;
  endtask

  task automatic count_release(output int n);
    n = 0;
    while (!clk_release && n < 40) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic hold_then_grant(string tag, bit use_lock);
    repeat (8) @(negedge clk);
    chk({tag, " held"}, clk_release, 0);
    if (use_lock) pll_lock = 1; else ost_done = 1;
    @(negedge clk);
    chk({tag, " granted"}, clk_release, 1);
    ost_done = 0; pll_lock = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cpu", cpu_clk_en, 1);
    chk("R1 per", per_clk_en, 1);
    chk("R1 osc", osc_run, 1);
    chk("R1 rel", clk_release, 1);

    // table walk: R3, R8, R9, R10, R11
    foreach (VEC[i]) begin
      osc_sel = VEC[i][5:3]; lp_keep = VEC[i][2];
      ost_done = (VEC[i][1:0] == 2'd2);
      pll_lock = (VEC[i][1:0] == 2'd1);
      go_sleep();
      chk("R3 cpu", cpu_clk_en, 0);
      chk("R3 per", per_clk_en, 0);
      chk("R3 rel", clk_release, 0);
      chk("R3 osc", osc_run, (VEC[i][5:3] == 3'd5 && VEC[i][2]) ? 1 : 0);
      wake_irq();
      chk("R11 osc", osc_run, 1);
      chk("R11 cpu", cpu_clk_en, 0);
      if (VEC[i][1:0] == 2'd0) begin
        count_release(n);
        chk("R8 cycles", n, POR + 1);
      end else if (VEC[i][1:0] == 2'd1) begin
        ost_done = 0;
        hold_then_grant("R9", 0);
      end else begin
        pll_lock = 0;
        hold_then_grant("R10", 1);
      end
      chk("R11 cpu on", cpu_clk_en, 1);
      lp_keep = 0; ost_done = 0; pll_lock = 0;
    end
    osc_sel = 3'd0;

    // R2 idle, R6 low-priority enabled request leaves idle
    @(negedge clk); cmd_valid = 1; cmd_sleep = 0;
    @(negedge clk); cmd_valid = 0;
    chk("R2 cpu", cpu_clk_en, 0);
    chk("R2 per", per_clk_en, 1);
    chk("R2 rel", clk_release, 1);
    irq_en[1] = 1; irq_prio[5:3] = 3'd1; irq_req[1] = 1;
    @(negedge clk); irq_req[1] = 0;
    chk("R6 idle wake", cpu_clk_en, 1);

    // R4, R5: ignored events in sleep
    go_sleep();
    chk("R4 lprc off", lprc_run, 0);
    irq_req[1] = 1;
    repeat (3) @(negedge clk);
    irq_req[1] = 0;
    chk("R5 low prio osc", osc_run, 0);
    irq_en[2] = 0; irq_prio[8:6] = 3'd7; irq_req[2] = 1;
    repeat (3) @(negedge clk);
    irq_req[2] = 0;
    chk("R5 disabled osc", osc_run, 0);
    wdt_timeout = 1;
    repeat (2) @(negedge clk);
    wdt_timeout = 0;
    chk("R5 wdt off osc", osc_run, 0);
    wdt_en = 1;
    @(negedge clk);
    chk("R4 lprc on", lprc_run, 1);
    wdt_timeout = 1;
    @(negedge clk); wdt_timeout = 0;
    chk("R5 wdt wake", osc_run, 1);
    count_release(n);
    chk("R5 wdt release", n, POR + 1);
    wdt_en = 0;

    // R5 reset source
    go_sleep();
    rst_src = 3'b010;
    @(negedge clk); rst_src = '0;
    chk("R5 rst wake", osc_run, 1);
    count_release(n);
    chk("R5 rst release", n, POR + 1);

    // R7 switching disabled -> default source (PLL)
    clk_switch_en = 0; osc_sel = 3'd0;
    go_sleep();
    wake_irq();
    hold_then_grant("R7 default", 1);
    clk_switch_en = 1;

    // R7 osc_sel change during sleep ignored
    osc_sel = 3'd0;
    go_sleep();
    osc_sel = 3'd6;
    @(negedge clk);
    wake_irq();
    count_release(n);
    chk("R7 captured", n, POR + 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule